// File: doc/BRIEF.md
# Chained Device-to-Memory DMA Channel

This block is one DMA channel that moves a burst of bytes from a device into memory. Software programs a current pointer, a limit, a chained start/stop pair and an optional one-shot buffer address through a 32-bit register bus, then turns the channel on with command bits in a control/status register. A device then asks for a transfer with a byte count. The channel streams the burst to memory one 32-bit word per accepted cycle, padding the tail with zero bytes up to the channel's alignment.

When the last word has been accepted, the channel records where the burst went in two saved registers. Unless chaining is suppressed, it reloads its current pointer and limit from the start/stop pair, so the next burst lands in the buffer that was queued behind it. It then sets a completion flag and raises its interrupt for one cycle. A non-zero one-shot buffer address takes the place of the current pointer for exactly one burst and is cleared when that burst ends.

The alignment is 16 bytes for a storage channel and 32 bytes for a network channel, chosen by a parameter.

Top module: `dmach_top`

## Requirements
- R1: After reset every register reads zero, and `busy`, `irq` and `mem_valid` are low.
- R2: A write to the control/status register (offset 0x0000) acts through command bits. Bit 0 sets enable, bit 1 sets the device-to-memory direction flag, bit 2 sets the chain-suppress flag, and bit 3 clears the complete flag. A zero in a command bit leaves its flag unchanged. A read returns enable in bit 0, direction in bit 1, suppress in bit 2 and complete in bit 3, with zeros above.
- R3: Command bit 4 clears enable, direction, suppress and complete together, and it wins over set commands given in the same write.
- R4: The registers are placed at these offsets: current pointer 0x4000, limit 0x4004, chain start 0x4008, chain stop 0x400C and one-shot buffer 0x4200, all read/write. Saved pointer (0x4100) and saved limit (0x4104) are read-only. A write to any other address, including one whose two low bits are not zero, changes nothing. A read of such an address returns zero.
- R5: A transfer request is ignored while enable is clear or while a burst is in progress: no memory write and no change to any register.
- R6: The burst starts at the one-shot buffer address if that register is non-zero, and otherwise at the current pointer. Words go to consecutive addresses 4 apart. `mem_valid` with its address and data is held until `mem_ready` is high.
- R7: The byte count is rounded up to a multiple of the alignment (16 bytes with the default parameter), and rounded/4 words are written. Byte k of the burst sits in word k/4 at bits [31-8*(k%4) -: 8]. Bytes at or beyond the requested count are written as zero. A count of zero writes no word but still completes.
- R8: At completion the saved pointer takes the current pointer's value, the saved limit takes that value plus the rounded count, and the one-shot buffer register becomes zero.
- R9: At completion, with chain-suppress clear, the current pointer and limit load from chain start and chain stop. With chain-suppress set, they keep their values.
- R10: `irq` is high for exactly the one cycle after the edge that accepts the last word (or after the accepting edge for a zero count), and the complete flag reads 1 from the next cycle on. `busy` is high from the cycle after the request is accepted through that `irq` cycle.
- R11: `dev_pop` is high exactly in cycles where a word is handed over (`mem_valid` and `mem_ready`), so the device advances once per word written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 16 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| xfer_req | input | 1 | Device transfer request |
| xfer_len | input | LEN_W | Burst byte count |
| dev_data | input | 32 | Current device word, first byte in bits 31:24 |
| dev_pop | output | 1 | Device word consumed this cycle |
| mem_valid | output | 1 | Memory write valid |
| mem_addr | output | 32 | Memory write byte address |
| mem_data | output | 32 | Memory write data |
| mem_ready | input | 1 | Memory accepts the write |
| busy | output | 1 | Burst in progress |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
The hold-stability property assumes the device keeps `dev_data` steady until a word is popped. It also assumes software does not write the pointer, chaining or one-shot registers while `busy` is high, since a write there could move a burst's completion values. The bench supplies device words from an array indexed by a pointer that advances only on `dev_pop`, and it issues register writes only once the channel is idle. `mem_ready` is varied between always-high and irregular patterns, and extra requests are injected during a burst to exercise the ignore rule.

// File: rtl/dmach_pkg.sv
package dmach_pkg;
  localparam logic [15:0] OFS_CSR    = 16'h0000;
  localparam logic [15:0] OFS_NEXT   = 16'h4000;
  localparam logic [15:0] OFS_LIMIT  = 16'h4004;
  localparam logic [15:0] OFS_START  = 16'h4008;
  localparam logic [15:0] OFS_STOP   = 16'h400C;
  localparam logic [15:0] OFS_SNEXT  = 16'h4100;
  localparam logic [15:0] OFS_SLIMIT = 16'h4104;
  localparam logic [15:0] OFS_INIT   = 16'h4200;

  // control/status command and flag bit positions
  localparam int CB_EN   = 0;
  localparam int CB_DIR  = 1;
  localparam int CB_SUPD = 2;
  localparam int CB_CMP  = 3;
  localparam int CB_RST  = 4;

  typedef enum logic [1:0] {BS_IDLE, BS_WRITE, BS_FIN} burst_state_e;

  // round a byte count up to a multiple of 2**lg
  function automatic logic [31:0] round_up(input logic [31:0] len, input int unsigned lg);
    logic [31:0] m;
    m = (32'd1 << lg) - 32'd1;
    return (len + m) & ~m;
  endfunction

  // keep only the bytes of word widx that lie below len
  function automatic logic [31:0] mask_word(input logic [31:0] word, input logic [31:0] widx,
                                            input logic [31:0] len);
    logic [31:0] res;
    res = '0;
    for (int b = 0; b < 4; b++) begin
      if (((widx << 2) + 32'(b)) < len) res[31-8*b -: 8] = word[31-8*b -: 8];
    end
    return res;
  endfunction
endpackage

// File: rtl/dmach_regs.sv
module dmach_regs
  import dmach_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [15:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        done,
  input  logic [31:0] done_size,
  output logic [31:0] next_q,
  output logic [31:0] init_q,
  output logic        en_q,
  output logic        cmp_q
);
  logic [31:0] limit_q, start_q, stop_q, snext_q, slimit_q;
  logic        dir_q, supd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q <= '0; limit_q <= '0; start_q <= '0; stop_q <= '0;
      init_q <= '0; snext_q <= '0; slimit_q <= '0;
      en_q <= 1'b0; dir_q <= 1'b0; supd_q <= 1'b0; cmp_q <= 1'b0;
    end else begin
      if (reg_wr) begin
        case (reg_addr)
          OFS_CSR: begin
            if (reg_wdata[CB_EN])   en_q   <= 1'b1;
            if (reg_wdata[CB_DIR])  dir_q  <= 1'b1;
            if (reg_wdata[CB_SUPD]) supd_q <= 1'b1;
            if (reg_wdata[CB_CMP])  cmp_q  <= 1'b0;
            if (reg_wdata[CB_RST]) begin
              en_q <= 1'b0; dir_q <= 1'b0; supd_q <= 1'b0; cmp_q <= 1'b0;
            end
          end
          OFS_NEXT:  next_q  <= reg_wdata;
          OFS_LIMIT: limit_q <= reg_wdata;
          OFS_START: start_q <= reg_wdata;
          OFS_STOP:  stop_q  <= reg_wdata;
          OFS_INIT:  init_q  <= reg_wdata;
          default: ;
        endcase
      end
      if (done) begin
        snext_q  <= next_q;
        slimit_q <= next_q + done_size;
        init_q   <= '0;
        cmp_q    <= 1'b1;
        if (!supd_q) begin
          next_q  <= start_q;
          limit_q <= stop_q;
        end
      end
    end
  end

  always_comb begin
    case (reg_addr)
      OFS_CSR:    reg_rdata = {28'd0, cmp_q, supd_q, dir_q, en_q};
      OFS_NEXT:   reg_rdata = next_q;
      OFS_LIMIT:  reg_rdata = limit_q;
      OFS_START:  reg_rdata = start_q;
      OFS_STOP:   reg_rdata = stop_q;
      OFS_SNEXT:  reg_rdata = snext_q;
      OFS_SLIMIT: reg_rdata = slimit_q;
      OFS_INIT:   reg_rdata = init_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/dmach_burst.sv
module dmach_burst
  import dmach_pkg::*;
#(
  parameter int ALIGN_LOG2 = 4,
  parameter int LEN_W      = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      base,
  input  logic [LEN_W-1:0] len,
  input  logic [31:0]      dev_data,
  input  logic             mem_ready,
  output logic             mem_valid,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_data,
  output logic             dev_pop,
  output logic             busy,
  output logic             done,
  output logic [31:0]      size_q
);
  burst_state_e st_q;
  logic [31:0]  addr_q, idx_q, words_q, len_q;
  logic [31:0]  len_ext, size_d;

  assign len_ext = 32'(len);
  assign size_d  = round_up(len_ext, ALIGN_LOG2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= BS_IDLE;
      addr_q <= '0; idx_q <= '0; words_q <= '0; len_q <= '0; size_q <= '0;
    end else begin
      case (st_q)
        BS_IDLE: if (start) begin
          addr_q  <= base;
          idx_q   <= '0;
          len_q   <= len_ext;
          size_q  <= size_d;
          words_q <= size_d >> 2;
          st_q    <= (size_d == 32'd0) ? BS_FIN : BS_WRITE;
        end
        BS_WRITE: if (mem_ready) begin
          addr_q <= addr_q + 32'd4;
          idx_q  <= idx_q + 32'd1;
          if (idx_q == words_q - 32'd1) st_q <= BS_FIN;
        end
        BS_FIN:  st_q <= BS_IDLE;
        default: st_q <= BS_IDLE;
      endcase
    end
  end

  assign mem_valid = (st_q == BS_WRITE);
  assign mem_addr  = addr_q;
  assign mem_data  = mask_word(dev_data, idx_q, len_q);
  assign dev_pop   = mem_valid && mem_ready;
  assign busy      = (st_q != BS_IDLE);
  assign done      = (st_q == BS_FIN);
endmodule

// File: rtl/dmach_top.sv
module dmach_top
  import dmach_pkg::*;
#(
  parameter bit NET_CHAN = 1'b0,
  parameter int LEN_W    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [15:0]      reg_addr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  input  logic             xfer_req,
  input  logic [LEN_W-1:0] xfer_len,
  input  logic [31:0]      dev_data,
  output logic             dev_pop,
  output logic             mem_valid,
  output logic [31:0]      mem_addr,
  output logic [31:0]      mem_data,
  input  logic             mem_ready,
  output logic             busy,
  output logic             irq
);
  localparam int ALIGN_LOG2 = NET_CHAN ? 5 : 4;

  logic [31:0] next_q, init_q, base_addr, burst_size;
  logic        en_q, csr_complete, xfer_accept, burst_done;

  assign xfer_accept = xfer_req && en_q && !busy;
  assign base_addr   = (init_q != 32'd0) ? init_q : next_q;
  assign irq         = burst_done;

  dmach_regs u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .done(burst_done),
    .done_size(burst_size), .next_q(next_q), .init_q(init_q),
    .en_q(en_q), .cmp_q(csr_complete)
  );

  dmach_burst #(.ALIGN_LOG2(ALIGN_LOG2), .LEN_W(LEN_W)) u_burst (
    .clk(clk), .rst_n(rst_n), .start(xfer_accept), .base(base_addr),
    .len(xfer_len), .dev_data(dev_data), .mem_ready(mem_ready),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .dev_pop(dev_pop), .busy(busy), .done(burst_done), .size_q(burst_size)
  );
endmodule

// File: rtl/dmach_chk.sv
module dmach_chk #(
  parameter int ALIGN_LOG2 = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_data,
  input logic        irq,
  input logic        csr_complete,
  input logic [31:0] init_q,
  input logic [31:0] burst_size
);
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R6
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && mem_ready) |=> (!mem_valid || mem_addr == $past(mem_addr) + 32'd4)); // R6
  AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R10
  AST_IRQ_COMPLETE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> csr_complete); // R10
  AST_INIT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> (init_q == 32'd0)); // R8
  AST_SIZE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (burst_size[ALIGN_LOG2-1:0] == '0)); // R7
endmodule

bind dmach_top dmach_chk #(.ALIGN_LOG2(ALIGN_LOG2)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_valid(mem_valid), .mem_ready(mem_ready),
  .mem_addr(mem_addr), .mem_data(mem_data), .irq(irq),
  .csr_complete(csr_complete), .init_q(init_q), .burst_size(burst_size)
);

// File: tb/tb_dmach_top.sv
`timescale 1ns/1ps
module tb_dmach_top;
  localparam int ALIGN = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        xfer_req = 1'b0;
  logic [11:0] xfer_len = '0;
  logic [31:0] dev_data;
  logic        dev_pop, mem_valid, mem_ready, busy, irq;
  logic [31:0] mem_addr, mem_data;

  always #2.5 clk = ~clk;

  dmach_top dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_req(xfer_req),
    .xfer_len(xfer_len), .dev_data(dev_data), .dev_pop(dev_pop),
    .mem_valid(mem_valid), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_ready(mem_ready), .busy(busy), .irq(irq)
  );

  // device payload and pointer
  logic [7:0] pay [0:255];
  int dptr = 0;
  bit pop_seen = 0;
  always_comb dev_data = {pay[(4*dptr)%256], pay[(4*dptr+1)%256], pay[(4*dptr+2)%256], pay[(4*dptr+3)%256]};

  // ready pattern
  int rdy_mode = 0;
  int rdy_cnt = 0;
  always @(posedge clk) begin
    #1;
    rdy_cnt = rdy_cnt + 1;
    mem_ready = (rdy_mode == 0) ? 1'b1 : ((rdy_cnt % 3) != 1);
  end

  // behavioural reference model
  bit m_en = 0, m_dir = 0, m_supd = 0, m_cmp = 0;
  logic [31:0] m_next = 0, m_limit = 0, m_start = 0, m_stop = 0, m_init = 0, m_snext = 0, m_slimit = 0;
  int m_st = 0;
  int m_idx = 0, m_words = 0, m_len = 0, m_size = 0;
  logic [31:0] m_addr = 0;

  always @(posedge clk) begin
    bit fin;
    if (pop_seen) dptr = dptr + 1;
    if (m_st == 0 && xfer_req) dptr = 0;
    if (!rst_n) begin
      m_en = 0; m_dir = 0; m_supd = 0; m_cmp = 0;
      m_next = 0; m_limit = 0; m_start = 0; m_stop = 0; m_init = 0; m_snext = 0; m_slimit = 0;
      m_st = 0; m_idx = 0; m_words = 0; m_len = 0; m_size = 0; m_addr = 0;
    end else begin
      fin = (m_st == 2);
      if (m_st == 0) begin
        if (xfer_req && m_en) begin
          m_len = int'(xfer_len);
          m_size = ((m_len + ALIGN - 1) / ALIGN) * ALIGN;
          m_words = m_size / 4;
          m_addr = (m_init != 0) ? m_init : m_next;
          m_idx = 0;
          m_st = (m_words == 0) ? 2 : 1;
        end
      end else if (m_st == 1) begin
        if (mem_ready) begin
          m_idx = m_idx + 1;
          m_addr = m_addr + 4;
          if (m_idx == m_words) m_st = 2;
        end
      end else m_st = 0;
      if (reg_wr) begin
        case (reg_addr)
          16'h0000: begin
            if (reg_wdata[4]) begin m_en = 0; m_dir = 0; m_supd = 0; m_cmp = 0; end
            else begin
              if (reg_wdata[0]) m_en = 1;
              if (reg_wdata[1]) m_dir = 1;
              if (reg_wdata[2]) m_supd = 1;
              if (reg_wdata[3]) m_cmp = 0;
            end
          end
          16'h4000: m_next = reg_wdata;
          16'h4004: m_limit = reg_wdata;
          16'h4008: m_start = reg_wdata;
          16'h400C: m_stop = reg_wdata;
          16'h4200: m_init = reg_wdata;
          default: ;
        endcase
      end
      if (fin) begin
        m_snext = m_next;
        m_slimit = m_next + 32'(m_size);
        m_init = 0;
        m_cmp = 1;
        if (!m_supd) begin m_next = m_start; m_limit = m_stop; end
      end
    end
  end

  function automatic logic [31:0] exp_word(input int widx);
    logic [31:0] w;
    w = '0;
    for (int b = 0; b < 4; b++)
      if (widx*4 + b < m_len) w[31-8*b -: 8] = pay[(widx*4+b)%256];
    return w;
  endfunction

  // per-cycle comparison
  bit cmp_on = 0;
  int cyc_chk = 0, cyc_fail = 0, irq_cnt = 0;
  always @(negedge clk) begin
    pop_seen = dev_pop;
    if (irq) irq_cnt = irq_cnt + 1;
    if (cmp_on) begin
      cyc_chk = cyc_chk + 4;
      if (mem_valid !== (m_st == 1) || (mem_valid && mem_addr !== m_addr)) begin
        cyc_fail++; $display("FAIL R6 t=%0t valid=%b addr=%h exp valid=%b addr=%h", $time, mem_valid, mem_addr, m_st == 1, m_addr);
      end
      if (m_st == 1 && mem_data !== exp_word(m_idx)) begin
        cyc_fail++; $display("FAIL R7 t=%0t data=%h exp=%h", $time, mem_data, exp_word(m_idx));
      end
      if (busy !== (m_st != 0) || irq !== (m_st == 2)) begin
        cyc_fail++; $display("FAIL R10 t=%0t busy=%b irq=%b exp busy=%b irq=%b", $time, busy, irq, m_st != 0, m_st == 2);
      end
      if (dev_pop !== (m_st == 1 && mem_ready)) begin
        cyc_fail++; $display("FAIL R11 t=%0t pop=%b exp=%b", $time, dev_pop, m_st == 1 && mem_ready);
      end
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [15:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_check(input logic [15:0] a, input logic [31:0] exp, input string req);
    reg_addr = a; #1;
    chk(reg_rdata, exp, req);
  endtask

  task automatic run_burst(input int len, input bit poke);
    for (int i = 0; i < 256; i++) pay[i] = (i < len) ? 8'(i*13 + len + 1) : 8'hEE;
    @(posedge clk); #1;
    xfer_req = 1'b1; xfer_len = 12'(len);
    @(posedge clk); #1;
    xfer_req = 1'b0;
    if (poke) begin
      repeat (2) @(posedge clk);
      #1 xfer_req = 1'b1;
      @(posedge clk); #1 xfer_req = 1'b0;
    end
    while (m_st != 0) begin @(posedge clk); #1; end
  endtask

  initial begin
    #(200000 * 5);
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_chk + cyc_chk + 1, n_fail + cyc_fail + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) pay[i] = 8'h00;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    cmp_on = 1;
    // R1: reset state
    reg_check(16'h0000, 32'h0, "R1 csr");
    reg_check(16'h4000, 32'h0, "R1 next");
    reg_check(16'h4104, 32'h0, "R1 saved limit");
    chk({31'd0, busy}, 32'h0, "R1 busy");
    chk({31'd0, irq}, 32'h0, "R1 irq");
    chk({31'd0, mem_valid}, 32'h0, "R1 mem_valid");

    // R5: request while disabled is ignored
    run_burst(8, 0);
    repeat (5) @(posedge clk); #1;
    reg_check(16'h0000, 32'h0, "R5 csr after disabled request");
    reg_check(16'h4100, 32'h0, "R5 saved pointer untouched");
    chk(irq_cnt, 0, "R5 no irq");

    // R2: command bits
    reg_write(16'h0000, 32'h1); reg_check(16'h0000, 32'h1, "R2 set enable");
    reg_write(16'h0000, 32'h2); reg_check(16'h0000, 32'h3, "R2 set direction");
    reg_write(16'h0000, 32'h0); reg_check(16'h0000, 32'h3, "R2 zero write no effect");
    reg_write(16'h0000, 32'h4); reg_check(16'h0000, 32'h7, "R2 set suppress");
    // R3: reset command wins
    reg_write(16'h0000, 32'h17); reg_check(16'h0000, 32'h0, "R3 reset wins");
    reg_write(16'h0000, 32'h1); reg_check(16'h0000, 32'h1, "R3 re-enable");

    // R4: register map
    reg_write(16'h4000, 32'h0000_1000);
    reg_write(16'h4004, 32'h0000_1040);
    reg_write(16'h4008, 32'h0000_2000);
    reg_write(16'h400C, 32'h0000_2080);
    reg_check(16'h4000, 32'h0000_1000, "R4 next");
    reg_check(16'h4004, 32'h0000_1040, "R4 limit");
    reg_check(16'h4008, 32'h0000_2000, "R4 start");
    reg_check(16'h400C, 32'h0000_2080, "R4 stop");
    reg_write(16'h4002, 32'hDEAD_BEEF);
    reg_check(16'h4000, 32'h0000_1000, "R4 unaligned write ignored");
    reg_check(16'h4002, 32'h0, "R4 unaligned read zero");
    reg_check(16'h4010, 32'h0, "R4 unmapped read zero");
    reg_write(16'h4100, 32'h1234_5678);
    reg_check(16'h4100, 32'h0, "R4 saved pointer read-only");

    // burst 20 bytes -> 32, chaining on
    run_burst(20, 0);
    reg_check(16'h4100, 32'h0000_1000, "R8 saved pointer");
    reg_check(16'h4104, 32'h0000_1020, "R8 saved limit");
    reg_check(16'h4000, 32'h0000_2000, "R9 next reloaded");
    reg_check(16'h4004, 32'h0000_2080, "R9 limit reloaded");
    reg_check(16'h0000, 32'h9, "R10 complete set");
    chk(irq_cnt, 1, "R10 one irq");
    reg_write(16'h0000, 32'h8); reg_check(16'h0000, 32'h1, "R2 clear complete");

    // one-shot buffer with irregular ready, exact length
    rdy_mode = 1;
    reg_write(16'h4200, 32'h0000_3000);
    reg_check(16'h4200, 32'h0000_3000, "R4 init buffer");
    run_burst(16, 0);
    reg_check(16'h4200, 32'h0, "R8 init cleared");
    reg_check(16'h4100, 32'h0000_2000, "R8 saved pointer with init");
    reg_check(16'h4104, 32'h0000_2010, "R7 exact length not padded");

    // suppress chaining, extra request during burst
    reg_write(16'h0000, 32'h4);
    reg_write(16'h4008, 32'h0000_5000);
    reg_write(16'h400C, 32'h0000_5100);
    run_burst(33, 1);
    reg_check(16'h4000, 32'h0000_2000, "R9 next kept");
    reg_check(16'h4004, 32'h0000_2080, "R9 limit kept");
    reg_check(16'h4104, 32'h0000_2030, "R7 33 rounds to 48");
    chk(irq_cnt, 3, "R5 request while busy ignored");

    // zero length
    run_burst(0, 0);
    reg_check(16'h4104, 32'h0000_2000, "R7 zero length");
    chk(irq_cnt, 4, "R7 zero length completes");

    rdy_mode = 0;
    run_burst(60, 0);
    reg_check(16'h4104, 32'h0000_2040, "R7 60 rounds to 64");
    repeat (3) @(posedge clk);
    #1;
    $display("[TB] %0d tests run, %0d failed", n_chk + cyc_chk, n_fail + cyc_fail);
    $finish;
  end
endmodule